// File: doc/BRIEF.md
# Triple Reloading Down-Counter Timer

This block holds three independent down-counting timer channels behind a small 32-bit register read/write bus. Two channels are 16 bits wide and one is 32 bits wide. Each channel has four registers: a reload value, a live count, a control word and an acknowledge register. Software starts a channel by writing its reload value and then setting the enable bit in the control word. From then on the count drops by one on every pulse of the tick the channel has selected. When the count passes below zero, the channel raises its own interrupt line.

Two tick-enable streams are built inside the unit from the bus clock by free-running dividers: a faster one and a slower one. Each channel picks one of them with a control bit. In periodic mode a channel restarts from its reload value after each underflow. In free-running mode it wraps to its all-ones value instead. A write of any data to a channel's acknowledge register drops that channel's interrupt.

Top module: `tmr3_unit`

## Requirements
- R1: Channel register groups sit at byte addresses 0x00, 0x20 and 0x80. Within a group the reload register is at +0x0, the live count at +0x4, the control word at +0x8 and the acknowledge register at +0xC. A read puts its data on `bus_rdata` in the cycle after `bus_rd`, and `bus_rdata` is zero in every other cycle. The acknowledge register and unmapped addresses read as zero.
- R2: Channels 0 and 1 are 16 bits wide and channel 2 is 32 bits wide. Written values are cut to the channel width, and count and reload bits above that width read as zero.
- R3: A write to the reload register also loads the counter in the same edge, so the next read of the count returns the written value. The load takes priority over a tick in that cycle.
- R4: Control bit 7 enables the channel, bit 6 selects periodic mode and bit 3 selects the fast tick (0 selects the slow tick). The control register reads back these three bits and zero elsewhere. An enabled channel decrements by one on each pulse of its selected tick.
- R5: On a tick with the count at zero, a channel in periodic mode reloads from its reload register and a channel in free-running mode takes its all-ones value. In both modes the channel's interrupt is set.
- R6: A write to a channel's acknowledge register clears that channel's interrupt, whatever the data. If an underflow of the same channel happens in the same cycle, the interrupt stays set.
- R7: The fast tick is a one-cycle pulse once every FAST_DIV clocks and the slow tick is a one-cycle pulse once every SLOW_DIV clocks. Both run freely from reset.
- R8: After reset every reload value, count and control word is zero, the interrupts are low and `bus_rdata` is zero.
- R9: Writing 0 to the control word stops the channel. The count then holds its value until it is written or the channel is enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| irq | output | 3 | Per-channel interrupt, bit n for channel n |

## Verification
The bench targets the cycle where a channel sits at zero and a tick arrives. A design that drops this case would miss the interrupt, reload from the wrong source, or wrap a periodic channel to all ones. It also overlaps acknowledge writes with underflows on a channel that fires on every tick. A design that lets the acknowledge win would show the interrupt low just after a fresh underflow. Truncation is exercised by loading values wider than 16 bits and reading them back; a design that kept upper bits would read them back nonzero. Stopped channels are read twice far apart to catch a counter that keeps moving after its enable is cleared.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int DATA_W = 32;
  localparam int NUM_CH = 3;

  // control word bit positions
  localparam int CTL_EN_BIT   = 7;
  localparam int CTL_PER_BIT  = 6;
  localparam int CTL_FAST_BIT = 3;

  // register offsets inside a channel group
  localparam logic [7:0] OFF_LOAD = 8'h00;
  localparam logic [7:0] OFF_VAL  = 8'h04;
  localparam logic [7:0] OFF_CTL  = 8'h08;
  localparam logic [7:0] OFF_ACK  = 8'h0C;

  function automatic logic [7:0] ch_base(input int idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'h20;
      default: return 8'h80;
    endcase
  endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  generate
    if (DIV > 1) begin : g_pulse_chk
      // R7: a pulse never lasts two cycles when the divider exceeds one
      assert_tick_single_R7: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);
    end
  endgenerate

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic              ctl_we,
  input  logic              ack_we,
  input  logic [WIDTH-1:0]  ld_data,
  input  logic              ctl_en,
  input  logic              ctl_per,
  input  logic              ctl_fast,
  input  logic              tick_fast,
  input  logic              tick_slow,
  output logic [DATA_W-1:0] load_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] ctl_o,
  output logic              irq_o
);
  localparam logic [WIDTH-1:0] MAX = {WIDTH{1'b1}};

  logic [WIDTH-1:0] load_q;
  logic [WIDTH-1:0] cnt_q;
  logic             en_q, per_q, fast_q, irq_q;
  logic             step, wrap;

  assign step = en_q && (fast_q ? tick_fast : tick_slow);
  assign wrap = step && !ld_we && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '0;
      cnt_q  <= '0;
    end else if (ld_we) begin
      load_q <= ld_data;
      cnt_q  <= ld_data;
    end else if (wrap) begin
      cnt_q  <= per_q ? load_q : MAX;
    end else if (step) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      per_q  <= 1'b0;
      fast_q <= 1'b0;
    end else if (ctl_we) begin
      en_q   <= ctl_en;
      per_q  <= ctl_per;
      fast_q <= ctl_fast;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         irq_q <= 1'b0;
    else if (wrap)   irq_q <= 1'b1;
    else if (ack_we) irq_q <= 1'b0;
  end

  always_comb begin
    ctl_o               = '0;
    ctl_o[CTL_EN_BIT]   = en_q;
    ctl_o[CTL_PER_BIT]  = per_q;
    ctl_o[CTL_FAST_BIT] = fast_q;
  end

  assign load_o = DATA_W'(load_q);
  assign cnt_o  = DATA_W'(cnt_q);
  assign irq_o  = irq_q;

  // R3: a reload write shows up in the count at the next edge
  assert_load_imm_R3: assert property (@(posedge clk) disable iff (rst)
    ld_we |=> cnt_q == $past(ld_data));

  // R9: a stopped channel without a reload write keeps its count
  assert_hold_stopped_R9: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !ld_we) |=> $stable(cnt_q));

  // R5: a new interrupt comes with a count at the reload or all-ones value
  assert_irq_source_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> (cnt_q == load_q || cnt_q == MAX));

  // R6: an acknowledge can only fail to clear on a running channel
  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    ack_we |=> (!irq_q || $past(en_q)));

endmodule

// File: rtl/tmr3_unit.sv
module tmr3_unit
  import tmr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CH0_W    = 16,
  parameter int CH1_W    = 16,
  parameter int CH2_W    = 32,
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [2:0]        irq
);
  logic tick_fast, tick_slow;

  tmr_tick_gen #(.DIV(FAST_DIV)) u_fast (.clk(clk), .rst(rst), .tick_o(tick_fast));
  tmr_tick_gen #(.DIV(SLOW_DIV)) u_slow (.clk(clk), .rst(rst), .tick_o(tick_slow));

  logic [DATA_W-1:0] load_v [NUM_CH];
  logic [DATA_W-1:0] cnt_v  [NUM_CH];
  logic [DATA_W-1:0] ctl_v  [NUM_CH];

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      localparam int W = (g == 0) ? CH0_W : (g == 1) ? CH1_W : CH2_W;
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(ch_base(g));

      logic ld_we, ctl_we, ack_we;
      assign ld_we  = bus_wr && (bus_addr == BASE + ADDR_W'(OFF_LOAD));
      assign ctl_we = bus_wr && (bus_addr == BASE + ADDR_W'(OFF_CTL));
      assign ack_we = bus_wr && (bus_addr == BASE + ADDR_W'(OFF_ACK));

      tmr_channel #(.WIDTH(W)) u_ch (
        .clk       (clk),
        .rst       (rst),
        .ld_we     (ld_we),
        .ctl_we    (ctl_we),
        .ack_we    (ack_we),
        .ld_data   (bus_wdata[W-1:0]),
        .ctl_en    (bus_wdata[CTL_EN_BIT]),
        .ctl_per   (bus_wdata[CTL_PER_BIT]),
        .ctl_fast  (bus_wdata[CTL_FAST_BIT]),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .load_o    (load_v[g]),
        .cnt_o     (cnt_v[g]),
        .ctl_o     (ctl_v[g]),
        .irq_o     (irq[g])
      );
    end
  endgenerate

  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(ch_base(i)) + ADDR_W'(OFF_LOAD)) rd_mux = load_v[i];
      if (bus_addr == ADDR_W'(ch_base(i)) + ADDR_W'(OFF_VAL))  rd_mux = cnt_v[i];
      if (bus_addr == ADDR_W'(ch_base(i)) + ADDR_W'(OFF_CTL))  rd_mux = ctl_v[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  // R1: read data is zero in any cycle not following a read strobe
  assert_rdata_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);

endmodule

// File: tb/tb_tmr3_unit.sv
module tb_tmr3_unit;
  localparam int FD = 3;
  localparam int SD = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tmr3_unit #(.ADDR_W(8), .CH0_W(16), .CH1_W(16), .CH2_W(32),
              .FAST_DIV(FD), .SLOW_DIV(SD)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  // ---------------- behavioural reference ----------------
  logic [31:0] m_load [3];
  logic [31:0] m_cnt  [3];
  logic        m_en [3], m_per [3], m_fast [3], m_irq [3];
  logic [31:0] m_rdata;
  int          fcnt, scnt;
  logic        ftick, stick;

  function automatic logic [31:0] wmask(input int i);
    return (i == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [7:0] gbase(input int i);
    return (i == 0) ? 8'h00 : (i == 1) ? 8'h20 : 8'h80;
  endfunction

  always @(posedge clk) begin
    logic [31:0] rv;
    logic        uf, stp;
    if (rst) begin
      for (int i = 0; i < 3; i++) begin
        m_load[i] = 0; m_cnt[i] = 0; m_en[i] = 0; m_per[i] = 0;
        m_fast[i] = 0; m_irq[i] = 0;
      end
      m_rdata = 0; fcnt = 0; scnt = 0; ftick = 0; stick = 0;
    end else begin
      rv = 0;
      if (bus_rd) begin
        for (int i = 0; i < 3; i++) begin
          if (bus_addr == gbase(i))      rv = m_load[i];
          if (bus_addr == gbase(i) + 4)  rv = m_cnt[i];
          if (bus_addr == gbase(i) + 8)
            rv = {24'd0, m_en[i], m_per[i], 2'b00, m_fast[i], 3'b000};
        end
      end
      m_rdata = rv;
      for (int i = 0; i < 3; i++) begin
        uf  = 0;
        stp = m_en[i] && (m_fast[i] ? ftick : stick);
        if (bus_wr && bus_addr == gbase(i)) begin
          m_load[i] = bus_wdata & wmask(i);
          m_cnt[i]  = bus_wdata & wmask(i);
        end else if (stp) begin
          if (m_cnt[i] == 0) begin
            m_cnt[i] = m_per[i] ? m_load[i] : wmask(i);
            uf = 1;
          end else begin
            m_cnt[i] = m_cnt[i] - 1;
          end
        end
        if (bus_wr && bus_addr == gbase(i) + 8) begin
          m_en[i] = bus_wdata[7]; m_per[i] = bus_wdata[6]; m_fast[i] = bus_wdata[3];
        end
        if (uf) m_irq[i] = 1;
        else if (bus_wr && bus_addr == gbase(i) + 12) m_irq[i] = 0;
      end
      if (fcnt == FD - 1) begin fcnt = 0; ftick = 1; end
      else begin fcnt = fcnt + 1; ftick = 0; end
      if (scnt == SD - 1) begin scnt = 0; stick = 1; end
      else begin scnt = scnt + 1; stick = 0; end
    end
  end

  // per-cycle comparison (R5 R6 R7 on interrupts, R1 on read data)
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (irq !== {m_irq[2], m_irq[1], m_irq[0]}) begin
        errors++;
        $display("FAIL R5 R6 R7 irq actual=%b expected=%b at %0t",
                 irq, {m_irq[2], m_irq[1], m_irq[0]}, $time);
      end
      checks++;
      if (bus_rdata !== m_rdata) begin
        errors++;
        $display("FAIL R1 rdata actual=%h expected=%h at %0t", bus_rdata, m_rdata, $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    v = bus_rdata;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    checks++;
    if (v !== exp) begin
      errors++;
      $display("FAIL %s read %h actual=%h expected=%h", tag, a, v, exp);
    end
  endtask

  task automatic chk(input logic cond, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_irq(input int ch);
    int n = 0;
    while (!irq[ch] && n < 500) begin @(negedge clk); n++; end
    chk(irq[ch] === 1'b1, "R5 interrupt never rose", {29'd0, irq}, 32'd1 << ch);
  endtask

  initial begin
    logic [31:0] v1, v2;
    repeat (3) @(negedge clk);
    rst = 0;
    // R8 reset state
    chk(irq === 3'b000, "R8 irq after reset", {29'd0, irq}, 0);
    rd_chk(8'h04, 0, "R8");
    rd_chk(8'h88, 0, "R8");
    rd_chk(8'h80, 0, "R8");

    // R2 R3 truncation and immediate load
    wr(8'h00, 32'h0001_2345);
    rd_chk(8'h04, 32'h0000_2345, "R2 R3");
    rd_chk(8'h00, 32'h0000_2345, "R2");
    wr(8'h80, 32'hFFFF_FFFF);
    rd_chk(8'h84, 32'hFFFF_FFFF, "R2");

    // R1 ack register and unmapped space read zero
    rd_chk(8'h0C, 0, "R1");
    rd_chk(8'h40, 0, "R1");

    // R4 control readback, other bits dropped
    wr(8'h28, 32'hFFFF_FFFF);
    rd_chk(8'h28, 32'h0000_00C8, "R4");
    wr(8'h28, 32'h0);

    // R5 periodic reload on channel 0, fast tick
    wr(8'h00, 32'd5);
    wr(8'h08, 32'h0000_00C8);
    wait_irq(0);
    rd_chk(8'h04, 32'd5, "R5 periodic reload");
    wr(8'h0C, 32'hDEAD_BEEF);
    chk(irq[0] === 1'b0, "R6 ack channel 0", {31'd0, irq[0]}, 0);
    idle(40);

    // R5 free-running wrap on channel 1
    wr(8'h20, 32'd2);
    wr(8'h28, 32'h0000_0088);
    wr(8'h2C, 32'h0);
    wait_irq(1);
    rd_chk(8'h24, 32'h0000_FFFF, "R5 free-running wrap");

    // R4 slow tick on channel 1 running freely for a while
    wr(8'h20, 32'd4);
    wr(8'h28, 32'h0000_00C0);
    idle(60);

    // R6 acks overlapping underflows on channel 2 (fires every fast tick)
    wr(8'h80, 32'd0);
    wr(8'h88, 32'h0000_00C8);
    for (int k = 0; k < 12; k++) wr(8'h8C, k);
    idle(5);

    // R9 stop holds the count
    wr(8'h08, 32'h0);
    rd(8'h04, v1);
    idle(20);
    rd(8'h04, v2);
    chk(v1 === v2, "R9 stopped count moved", v2, v1);
    wr(8'h88, 32'h0);
    idle(2);
    wr(8'h8C, 32'h0);
    chk(irq[2] === 1'b0, "R6 ack channel 2", {31'd0, irq[2]}, 0);

    // R3 load while running restarts from the new value
    wr(8'h20, 32'd300);
    rd_chk(8'h24, 32'd300, "R3 load on running channel");
    idle(30);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule